// File: doc/BRIEF.md
# Board Interrupt and Card-Status Controller

This block gathers twenty external interrupt lines from a board, brings each into the local clock domain through a two-stage synchronizer, and turns synchronized rising edges into sticky pending bits. A pending bit is only captured while its enable bit is set. Software owns both the enable and pending registers. A single interrupt line to the host stays high while any enabled bit is pending.

The block also holds one status/control word for each of two expansion-card slots. Each word has a ready flag that reads as one and an active-low card-present flag. That flag follows a dedicated interrupt line for the slot. Each word also has five host-writable power and reset control bits.

Software reaches everything through a plain synchronous register port that decodes a 1 MiB window. Read data is combinational from the address. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. The port always accepts, so there is no back-pressure.

Top module: `board_irq_ctrl`

## Requirements
- R1: After reset, the enable register (offset 0xC0) and the pending register (offset 0xD0) read 0, both slot words (offsets 0xE0 and 0xE4) read 0x420, and `irq_out` is low.
- R2: A write to 0xC0 or 0xD0 stores only the bits selected by 0x000FEEFF. All other bits read as 0.
- R3: A pending bit is set on the third rising clock edge after its input goes from low to high, and only if its enable bit is 1. Inputs that are not enabled latch nothing.
- R4: `irq_out` is high exactly when some bit is set in both pending and enable. It follows a write to either register from the next clock edge.
- R5: A write to 0xD0 replaces the pending bits with the written value. A bit written as 0 is cleared, and a level that stays high does not set it again without a new rising edge.
- R6: Bit 5 of slot 0 is the inverse of synchronized input 9, and bit 5 of slot 1 is the inverse of synchronized input 13. Each follows its input three edges after the input changes.
- R7: A write to a slot word changes only bits [4:0]. Bit 10 stays 1 and bit 5 keeps following its input.
- R8: Offsets other than 0xC0, 0xD0, 0xE0 and 0xE4 read as 0, and writes to them change no register.
- R9: If a pending-register write and an enabled rising edge land on the same clock edge, the result is the written value OR'ed with the edge bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 20 | Asynchronous external interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected offset |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
A software write to the pending register and a hardware rising edge on an enabled input can hit the same register on the same clock edge. The bench provokes this collision: it raises input 3 and then times a pending-register write carrying bit 7 so that it lands on the edge where input 3's synchronized edge is captured. The outcome is judged by reading back 0x88. A value of 0x80 would show that the write discarded the hardware event.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam logic [31:0] KEEP_BITS = 32'h000F_EEFF;
  localparam int unsigned OFS_MASK  = 32'h0C0;
  localparam int unsigned OFS_PEND  = 32'h0D0;
  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned READY_BIT = 10;
  localparam int unsigned NCD_BIT   = 5;
  localparam int unsigned CTRL_W    = 5;

  function automatic int unsigned slot_offset(int unsigned idx);
    return 32'h0E0 + 4 * idx;
  endfunction

  function automatic int unsigned slot_cd_line(int unsigned idx);
    return (idx == 0) ? 9 : 13;
  endfunction
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
  parameter int unsigned WIDTH  = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/bic_pending.sv
module bic_pending #(
  parameter int unsigned N_IRQ  = 20,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEEP = DATA_W'(32'h000F_EEFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  lvl,
  input  logic              wr_mask,
  input  logic              wr_pend,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] pend_q,
  output logic              irq_out
);
  logic [N_IRQ-1:0]  prev_q;
  logic [DATA_W-1:0] rise_w;
  logic [DATA_W-1:0] set_v;

  assign rise_w = DATA_W'(lvl & ~prev_q);
  assign set_v  = rise_w & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      if (wr_mask) mask_q <= wdata & KEEP;
      pend_q <= (wr_pend ? (wdata & KEEP) : pend_q) | set_v;
    end
  end

  assign irq_out = |(pend_q & mask_q);

  assert_keep_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~KEEP) == '0) && ((mask_q & ~KEEP) == '0));

  assert_pend_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) != '0) |-> ($past(wr_pend) || ($past(set_v) != '0)));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(wr_mask) || $past(wr_pend) || ($past(set_v) != '0)));

  assert_sw_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_pend) && ($past(set_v) == '0)) |-> (pend_q == ($past(wdata) & KEEP)));
endmodule

// File: rtl/bic_slot.sv
module bic_slot #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTRL_W    = 5,
  parameter int unsigned READY_BIT = 10,
  parameter int unsigned NCD_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wctrl,
  output logic [DATA_W-1:0] word
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ncd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ncd_q  <= 1'b1;
    end else begin
      ncd_q <= ~det;
      if (wr) ctrl_q <= wctrl;
    end
  end

  always_comb begin
    word            = '0;
    word[CTRL_W-1:0] = ctrl_q;
    word[NCD_BIT]   = ncd_q;
    word[READY_BIT] = 1'b1;
  end

  assert_ncd_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ncd_q == !$past(det)));

  assert_ctrl_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(wr));
endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import bic_pkg::*;
#(
  parameter int unsigned N_IRQ  = 20,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [N_IRQ-1:0]  sync_lvl;
  logic [DATA_W-1:0] mask_q, pend_q;
  logic              hit_mask, hit_pend;
  logic [NUM_SLOTS-1:0] hit_slot;
  logic [DATA_W-1:0] slot_word [NUM_SLOTS];

  assign hit_mask = bus_addr == ADDR_W'(OFS_MASK);
  assign hit_pend = bus_addr == ADDR_W'(OFS_PEND);

  bic_sync #(.WIDTH(N_IRQ), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_lvl)
  );

  bic_pending #(.N_IRQ(N_IRQ), .DATA_W(DATA_W), .KEEP(KEEP_BITS)) u_pend (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
    .wr_mask(bus_sel && bus_wr && hit_mask),
    .wr_pend(bus_sel && bus_wr && hit_pend),
    .wdata(bus_wdata), .mask_q(mask_q), .pend_q(pend_q), .irq_out(irq_out)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hit_slot[s] = bus_addr == ADDR_W'(slot_offset(s));
    bic_slot #(
      .DATA_W(DATA_W), .CTRL_W(CTRL_W), .READY_BIT(READY_BIT), .NCD_BIT(NCD_BIT)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .det(sync_lvl[slot_cd_line(s)]),
      .wr(bus_sel && bus_wr && hit_slot[s]),
      .wctrl(bus_wdata[CTRL_W-1:0]),
      .word(slot_word[s])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mask) bus_rdata = mask_q;
    if (hit_pend) bus_rdata = pend_q;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (hit_slot[s]) bus_rdata = slot_word[s];
  end

  assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !hit_mask && !hit_pend && (hit_slot == '0))
      |=> ($stable(mask_q) || ($past(mask_q) == '0 && mask_q == '0)));
endmodule

// File: tb/board_irq_ctrl_tb.sv
module board_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  board_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [19:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(string tag, logic exp);
    @(negedge clk);
    #1 check(tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  task automatic t_reset();
    rd("R1 mask", 20'h0C0, 32'h0);
    rd("R1 pend", 20'h0D0, 32'h0);
    rd("R1 slot0", 20'h0E0, 32'h420);
    rd("R1 slot1", 20'h0E4, 32'h420);
    chk_irq("R1 irq_out", 1'b0);
  endtask

  task automatic t_legal_bits();
    wr(20'h0C0, 32'hFFFF_FFFF);
    rd("R2 mask keep", 20'h0C0, 32'h000F_EEFF);
    wr(20'h0D0, 32'hFFFF_FFFF);
    rd("R2 pend keep", 20'h0D0, 32'h000F_EEFF);
    chk_irq("R4 irq after writes", 1'b1);
    wr(20'h0D0, 32'h0);
    rd("R5 pend cleared", 20'h0D0, 32'h0);
    chk_irq("R4 irq after clear", 1'b0);
    wr(20'h0C0, 32'h0);
  endtask

  task automatic t_latch();
    wr(20'h0C0, 32'h10);
    @(negedge clk); irq_in[4] = 1'b1; irq_in[2] = 1'b1;
    repeat (2) @(posedge clk);
    rd("R3 not before third edge", 20'h0D0, 32'h0);
    rd("R3 latched enabled only", 20'h0D0, 32'h10);
    chk_irq("R4 irq from latch", 1'b1);
    wr(20'h0D0, 32'h0);
    repeat (3) @(posedge clk);
    rd("R5 no relatch on level", 20'h0D0, 32'h0);
    chk_irq("R4 irq low after sw clear", 1'b0);
    @(negedge clk); irq_in = '0;
    repeat (3) @(posedge clk);
    wr(20'h0C0, 32'h0);
  endtask

  task automatic t_mask_gate();
    wr(20'h0D0, 32'h10);
    chk_irq("R4 masked pending no irq", 1'b0);
    wr(20'h0C0, 32'h10);
    chk_irq("R4 irq on enable write", 1'b1);
    wr(20'h0C0, 32'h0);
    wr(20'h0D0, 32'h0);
  endtask

  task automatic t_card_detect();
    @(negedge clk); irq_in[9] = 1'b1;
    repeat (3) @(posedge clk);
    rd("R6 slot0 card in", 20'h0E0, 32'h400);
    rd("R6 slot1 untouched", 20'h0E4, 32'h420);
    @(negedge clk); irq_in[13] = 1'b1;
    repeat (3) @(posedge clk);
    rd("R6 slot1 card in", 20'h0E4, 32'h400);
    wr(20'h0E0, 32'hFFFF_FFFF);
    rd("R7 slot0 ctrl only", 20'h0E0, 32'h41F);
    @(negedge clk); irq_in[9] = 1'b0; irq_in[13] = 1'b0;
    repeat (3) @(posedge clk);
    rd("R6 slot0 card out", 20'h0E0, 32'h43F);
    rd("R6 slot1 card out", 20'h0E4, 32'h420);
    wr(20'h0E4, 32'h0000_0412);
    rd("R7 slot1 partial write", 20'h0E4, 32'h432);
    wr(20'h0E0, 32'h0);
    rd("R7 slot0 ctrl cleared", 20'h0E0, 32'h420);
    wr(20'h0E4, 32'h0);
  endtask

  task automatic t_undef();
    wr(20'h0C4, 32'hFFFF_FFFF);
    wr(20'h0E8, 32'hFFFF_FFFF);
    wr(20'hF00C0, 32'hFFFF_FFFF);
    rd("R8 undef C4 reads 0", 20'h0C4, 32'h0);
    rd("R8 undef E8 reads 0", 20'h0E8, 32'h0);
    rd("R8 mask unchanged", 20'h0C0, 32'h0);
    rd("R8 pend unchanged", 20'h0D0, 32'h0);
    rd("R8 slot0 unchanged", 20'h0E0, 32'h420);
  endtask

  task automatic t_collide();
    wr(20'h0C0, 32'h88);
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (2) @(posedge clk);
    wr(20'h0D0, 32'h80);
    rd("R9 edge and write same edge", 20'h0D0, 32'h88);
    @(negedge clk); irq_in = '0;
    wr(20'h0C0, 32'h0);
    wr(20'h0D0, 32'h0);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_legal_bits();
    t_latch();
    t_mask_gate();
    t_card_detect();
    t_undef();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule